// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous logic use an external asynchronous static RAM that can be organised either as 16-bit words or as 8-bit bytes. The host side offers a single request port with address, write flag, write data and two byte-enables. The block answers with `hostReady`, read data and a one-cycle `hostDone`. Only one access is in flight at a time. On the memory side it drives two chip selects of opposite polarity, write and output strobes, two byte-lane strobes, the width-select pin, the address bus, and a data bus split into output value, per-bit output enable and input value.

Every phase length is derived at elaboration from nanosecond timing parameters and the clock period: divide, round up, never below one cycle. The `BYTE_MODE` parameter picks the organisation. In byte mode the width-select pin is held low and the top data pin carries the byte-address LSB. A write uses one select cycle, then a write-strobe pulse, then recovery. A read uses one select cycle, then an output-enable window whose last cycle captures the data, then a bus turnaround.

Top module: `asram_ctrl`

## Requirements
- R1: After reset `hostReady`=1 and `hostDone`=0. Both selects are inactive (`memCsN`=1, `memCs2`=0). `memWeN`, `memOeN`, `memLbN` and `memUbN` are all 1, and `memDqOe` is all zero.
- R2: A write has one cycle with the selects active and the write strobe high, then `memWeN` low for WP=max(ceil(tWP/T),ceil(tDW/T)) cycles. The data stays driven and stable for the whole pulse. `memWeN` is only ever low while both selects and at least one lane strobe are active.
- R3: A write keeps `hostReady` low for 1+WP+REC cycles, with REC=max(1, ceil(tWC/T)-1-WP). Write data stays driven through recovery.
- R4: A read has one select cycle, then `memOeN` low for RD=max(ceil(tRC/T),ceil(tAA/T),ceil(tOE/T)) cycles. Data is sampled on the last of these cycles and appears on `hostRdata` when `hostDone` is 1.
- R5: No data pin the memory can drive has `memDqOe` set while `memOeN` is low, or during the HZ=ceil(tHZ/T) cycles after it rises. A read keeps `hostReady` low for 1+RD+HZ cycles.
- R6: In word mode `memByteN`=1. Enable bit 0 maps to `memLbN` low and data bits 7:0, and enable bit 1 maps to `memUbN` low and bits 15:8. A lane that is not enabled is left unchanged in memory on a write and reads back as zero.
- R7: In byte mode `memByteN`=0, and `memLbN` and `memUbN` are both low whenever selected. `memAddr` is `hostAddr[ADDR_W:1]`, bit 15 of the data bus is driven with `hostAddr[0]`, and data uses bits 7:0 only.
- R8: A request with `hostBe`=00 gives `hostDone` on the next cycle without any select activity, and `hostReady` stays 1.
- R9: `hostDone` is high for exactly one cycle. `hostReady` is low from the cycle after acceptance until the end of the final phase, and always low while selected.
- R10: `memOeN` stays high throughout a write, and `memWeN` stays high throughout a read.
- R11: Each phase is at least one cycle, even when the ns-to-cycle arithmetic gives zero or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Request, accepted while hostReady is 1 |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W+BYTE_MODE (20) | Word address, or byte address in byte mode |
| hostWdata | input | 16 (8 in byte mode) | Write data |
| hostBe | input | 2 | Byte enables; 00 completes at once |
| hostReady | output | 1 | Idle and able to accept |
| hostRdata | output | 16 (8 in byte mode) | Read data, valid with hostDone |
| hostDone | output | 1 | One-cycle completion pulse |
| memCsN | output | 1 | Active-low chip select |
| memCs2 | output | 1 | Active-high chip select |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memLbN | output | 1 | Lower lane strobe, active low |
| memUbN | output | 1 | Upper lane strobe, active low |
| memByteN | output | 1 | Width select, low for byte organisation |
| memAddr | output | ADDR_W (20) | Memory address |
| memDqOut | output | 16 | Data bus value driven out |
| memDqOe | output | 16 | Per-bit drive enable for the data bus |
| memDqIn | input | 16 | Data bus value read back |

## Verification
The bench builds two instances. The first is a word-organised one at a 4 ns period with tRC=55 ns, giving a 10-cycle write pulse, 3 recovery cycles, a 14-cycle read window and a 5-cycle turnaround. The second is byte-organised with a 10 ns period and tRC=tAA=70 ns. There the recovery arithmetic drops to the one-cycle floor and the read window is set by the slower grade. A behavioural memory model on each instance commits writes at the trailing edge of the write window and serves reads from the pins, so lane merging and the byte-address LSB on bit 15 are observed at the memory. Per-clock monitors track strobe widths, data stability and bus contention against the phase lengths that the bench computes on its own.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_ACCESS,
    ST_REC,
    ST_TURN
  } phase_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;
    logic selOn;
    logic weOn;
    logic oeOn;
    logic busDrive;
    logic capture;
  } strobe_t;

  function automatic int nsToCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int WP_CYC  = 10,
  parameter int REC_CYC = 3,
  parameter int RD_CYC  = 14,
  parameter int HZ_CYC  = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostReq,
  input  logic    hostWrite,
  input  logic    beAny,
  output strobe_t stb,
  output logic    hostReady,
  output logic    hostDone
);

  localparam int MAX_CYC = maxOf(maxOf(WP_CYC, REC_CYC), maxOf(RD_CYC, HZ_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  phase_t           state;
  logic [CNT_W-1:0] cnt;
  logic             isWr;
  logic             doneQ;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      isWr  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (hostReq) begin
            if (beAny) begin
              state <= ST_SETUP;
              isWr  <= hostWrite;
            end else begin
              doneQ <= 1'b1;
            end
          end
        end
        ST_SETUP: begin
          state <= isWr ? ST_PULSE : ST_ACCESS;
          cnt   <= isWr ? CNT_W'(WP_CYC - 1) : CNT_W'(RD_CYC - 1);
        end
        ST_PULSE: begin
          if (cntZero) begin
            state <= ST_REC;
            cnt   <= CNT_W'(REC_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACCESS: begin
          if (cntZero) begin
            state <= ST_TURN;
            cnt   <= CNT_W'(HZ_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_REC, ST_TURN: begin
          if (cntZero) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.load     = (state == ST_IDLE) && hostReq && beAny;
    stb.selOn    = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_ACCESS);
    stb.weOn     = (state == ST_PULSE);
    stb.oeOn     = (state == ST_ACCESS);
    stb.busDrive = isWr && ((state == ST_SETUP) || (state == ST_PULSE) || (state == ST_REC));
    stb.capture  = (state == ST_ACCESS) && cntZero;
  end

  assign hostReady = (state == ST_IDLE);
  assign hostDone  = doneQ;

  AST_CAPTURE_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (state == ST_TURN)) else $error("capture not at read end"); // R4

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int BYTE_MODE = 0,
  localparam int HOST_AW  = ADDR_W + BYTE_MODE,
  localparam int HOST_DW  = (BYTE_MODE != 0) ? 8 : 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [HOST_DW-1:0] hostWdata,
  input  logic [1:0]         hostBe,
  output logic [HOST_DW-1:0] hostRdata,
  output logic               memCsN,
  output logic               memCs2,
  output logic               memWeN,
  output logic               memOeN,
  output logic               memLbN,
  output logic               memUbN,
  output logic               memByteN,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [15:0]        memDqOut,
  output logic [15:0]        memDqOe,
  input  logic [15:0]        memDqIn
);

  assign memCsN = ~stb.selOn;
  assign memCs2 = stb.selOn;
  assign memWeN = ~stb.weOn;
  assign memOeN = ~stb.oeOn;

  generate
    if (BYTE_MODE != 0) begin : g_byte
      logic [HOST_AW-1:0] addrQ;
      logic [7:0]         wdQ;
      logic [7:0]         rdQ;
      logic               unusedIn;

      assign unusedIn = ^{memDqIn[15:8], hostBe};

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          addrQ <= '0;
          wdQ   <= '0;
          rdQ   <= '0;
        end else begin
          if (stb.load) begin
            addrQ <= hostAddr;
            wdQ   <= hostWdata;
          end
          if (stb.capture) rdQ <= memDqIn[7:0];
        end
      end

      assign memByteN  = 1'b0;
      assign memLbN    = ~stb.selOn;
      assign memUbN    = ~stb.selOn;
      assign memAddr   = addrQ[HOST_AW-1:1];
      assign memDqOut  = {addrQ[0], 7'h00, wdQ};
      assign memDqOe   = {stb.selOn, 7'h00, {8{stb.busDrive}}};
      assign hostRdata = rdQ;

      AST_BYTE_LANES_LOW: assert property (@(posedge clk) disable iff (!rstN)
        !memCsN |-> (!memLbN && !memUbN && !memByteN)) else $error("byte lanes"); // R7
    end else begin : g_word
      logic [HOST_AW-1:0] addrQ;
      logic [15:0]        wdQ;
      logic [15:0]        rdQ;
      logic [1:0]         beQ;
      logic [15:0]        laneMask;

      assign laneMask = {{8{beQ[1]}}, {8{beQ[0]}}};

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          addrQ <= '0;
          wdQ   <= '0;
          rdQ   <= '0;
          beQ   <= '0;
        end else begin
          if (stb.load) begin
            addrQ <= hostAddr;
            wdQ   <= hostWdata;
            beQ   <= hostBe;
          end
          if (stb.capture) rdQ <= memDqIn & laneMask;
        end
      end

      assign memByteN  = 1'b1;
      assign memLbN    = ~(stb.selOn & beQ[0]);
      assign memUbN    = ~(stb.selOn & beQ[1]);
      assign memAddr   = addrQ;
      assign memDqOut  = wdQ;
      assign memDqOe   = {16{stb.busDrive}} & laneMask;
      assign hostRdata = rdQ;
    end
  endgenerate

  AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCsN && memCs2 && (!memLbN || !memUbN))) else $error("we outside select"); // R2

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memDqOut & memDqOe)) else $error("data moved"); // R2

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int BYTE_MODE     = 0,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_WP_NS       = 40,
  parameter int T_DW_NS       = 25,
  parameter int T_WC_NS       = 55,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_OE_NS       = 35,
  parameter int T_HZ_NS       = 20,
  localparam int HOST_AW      = ADDR_W + BYTE_MODE,
  localparam int HOST_DW      = (BYTE_MODE != 0) ? 8 : 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostReq,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [HOST_DW-1:0] hostWdata,
  input  logic [1:0]         hostBe,
  output logic               hostReady,
  output logic [HOST_DW-1:0] hostRdata,
  output logic               hostDone,
  output logic               memCsN,
  output logic               memCs2,
  output logic               memWeN,
  output logic               memOeN,
  output logic               memLbN,
  output logic               memUbN,
  output logic               memByteN,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [15:0]        memDqOut,
  output logic [15:0]        memDqOe,
  input  logic [15:0]        memDqIn
);

  localparam int WP_CYC  = maxOf(nsToCycles(T_WP_NS, CLK_PERIOD_NS),
                                 nsToCycles(T_DW_NS, CLK_PERIOD_NS));
  localparam int WC_CYC  = nsToCycles(T_WC_NS, CLK_PERIOD_NS);
  localparam int REC_CYC = maxOf(1, WC_CYC - 1 - WP_CYC);
  localparam int RD_CYC  = maxOf(maxOf(nsToCycles(T_RC_NS, CLK_PERIOD_NS),
                                       nsToCycles(T_AA_NS, CLK_PERIOD_NS)),
                                 nsToCycles(T_OE_NS, CLK_PERIOD_NS));
  localparam int HZ_CYC  = nsToCycles(T_HZ_NS, CLK_PERIOD_NS);
  localparam logic [15:0] BUS_MASK = (BYTE_MODE != 0) ? 16'h00FF : 16'hFFFF;
  localparam int HZ_W    = $clog2(HZ_CYC + 2);
  localparam int WE_W    = $clog2(WP_CYC + 2);

  strobe_t stb;

  asram_fsm #(
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC),
    .RD_CYC (RD_CYC),
    .HZ_CYC (HZ_CYC)
  ) u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .beAny    (|hostBe),
    .stb      (stb),
    .hostReady(hostReady),
    .hostDone (hostDone)
  );

  asram_datapath #(
    .ADDR_W   (ADDR_W),
    .BYTE_MODE(BYTE_MODE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .hostBe   (hostBe),
    .hostRdata(hostRdata),
    .memCsN   (memCsN),
    .memCs2   (memCs2),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .memLbN   (memLbN),
    .memUbN   (memUbN),
    .memByteN (memByteN),
    .memAddr  (memAddr),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .memDqIn  (memDqIn)
  );

  // cycles since the output enable was last low, and length of the write strobe
  logic [HZ_W-1:0] hzCnt;
  logic [WE_W-1:0] weRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hzCnt <= HZ_W'(HZ_CYC + 1);
      weRun <= '0;
    end else begin
      if (!memOeN) hzCnt <= '0;
      else if (hzCnt <= HZ_W'(HZ_CYC)) hzCnt <= hzCnt + 1'b1;
      if (memWeN) weRun <= '0;
      else if (weRun <= WE_W'(WP_CYC)) weRun <= weRun + 1'b1;
    end
  end

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || hzCnt < HZ_W'(HZ_CYC)) |-> ((memDqOe & BUS_MASK) == 16'h0)) else $error("bus fight"); // R5

  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weRun == WE_W'(WP_CYC))) else $error("we pulse length"); // R2

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN) else $error("oe during write"); // R10

  AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !memCsN |-> !hostReady) else $error("ready while selected"); // R9

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

  int nTests = 0;
  int nFails = 0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  function automatic int cdiv(input int ns, input int p);
    int c;
    c = (ns + p - 1) / p;
    if (c < 1) c = 1;
    return c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expected phase lengths, instance 0 (word, 4 ns) and 1 (byte, 10 ns, 70 ns read)
  int wpE[2], recE[2], rdE[2], hzE[2];
  initial begin
    wpE[0]  = mx(cdiv(40, 4), cdiv(25, 4));
    recE[0] = mx(1, cdiv(55, 4) - 1 - wpE[0]);
    rdE[0]  = mx(mx(cdiv(55, 4), cdiv(55, 4)), cdiv(35, 4));
    hzE[0]  = cdiv(20, 4);
    wpE[1]  = mx(cdiv(40, 10), cdiv(25, 10));
    recE[1] = mx(1, cdiv(55, 10) - 1 - wpE[1]);
    rdE[1]  = mx(mx(cdiv(70, 10), cdiv(70, 10)), cdiv(35, 10));
    hzE[1]  = cdiv(20, 10);
  end

  // word instance
  logic reqW = 0, wrW = 0;
  logic [19:0] hAddrW = '0;
  logic [15:0] hWdW = '0;
  logic [1:0]  hBeW = '0;
  logic readyW, doneW, csNW, cs2W, weNW, oeNW, lbNW, ubNW, byteNW;
  logic [15:0] rdW, dqOutW, dqOeW, dqInW;
  logic [19:0] mAddrW;

  asram_ctrl #(.ADDR_W(20), .BYTE_MODE(0), .CLK_PERIOD_NS(4)) u_asram_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(reqW), .hostWrite(wrW), .hostAddr(hAddrW),
    .hostWdata(hWdW), .hostBe(hBeW), .hostReady(readyW), .hostRdata(rdW), .hostDone(doneW),
    .memCsN(csNW), .memCs2(cs2W), .memWeN(weNW), .memOeN(oeNW), .memLbN(lbNW), .memUbN(ubNW),
    .memByteN(byteNW), .memAddr(mAddrW), .memDqOut(dqOutW), .memDqOe(dqOeW), .memDqIn(dqInW));

  // byte instance
  logic reqB = 0, wrB = 0;
  logic [20:0] hAddrB = '0;
  logic [7:0]  hWdB = '0;
  logic [1:0]  hBeB = '0;
  logic readyB, doneB, csNB, cs2B, weNB, oeNB, lbNB, ubNB, byteNB;
  logic [7:0]  rdB;
  logic [15:0] dqOutB, dqOeB, dqInB;
  logic [19:0] mAddrB;

  asram_ctrl #(.ADDR_W(20), .BYTE_MODE(1), .CLK_PERIOD_NS(10), .T_RC_NS(70), .T_AA_NS(70)) u_asram_ctrl_byte (
    .clk(clk), .rstN(rstN), .hostReq(reqB), .hostWrite(wrB), .hostAddr(hAddrB),
    .hostWdata(hWdB), .hostBe(hBeB), .hostReady(readyB), .hostRdata(rdB), .hostDone(doneB),
    .memCsN(csNB), .memCs2(cs2B), .memWeN(weNB), .memOeN(oeNB), .memLbN(lbNB), .memUbN(ubNB),
    .memByteN(byteNB), .memAddr(mAddrB), .memDqOut(dqOutB), .memDqOe(dqOeB), .memDqIn(dqInB));

  // behavioural memories
  logic [15:0] wMem [int];
  logic [7:0]  bMem [int];

  function automatic logic [15:0] peekW(input int a);
    return wMem.exists(a) ? wMem[a] : 16'h0000;
  endfunction
  function automatic logic [7:0] peekB(input int a);
    return bMem.exists(a) ? bMem[a] : 8'h00;
  endfunction

  always @* begin
    if (!csNW && cs2W && !oeNW && weNW) begin
      dqInW[7:0]  = !lbNW ? peekW(int'(mAddrW))[7:0]  : 8'hA5;
      dqInW[15:8] = !ubNW ? peekW(int'(mAddrW))[15:8] : 8'hA5;
    end else begin
      dqInW = 16'hDEAD;
    end
    if (!csNB && cs2B && !oeNB && weNB) dqInB = {8'h5A, peekB(int'({mAddrB, dqOutB[15]}))};
    else dqInB = 16'hBEEF;
  end

  // per-clock monitors
  int weLow[2], oeLow[2], selCnt[2], stabErr[2], contErr[2], pinErr[2];
  int hz[2];
  logic wrPrev[2];
  logic [15:0] lastD[2], pendD[2];
  logic [1:0]  pendL;
  int pendA[2];
  initial begin
    for (int i = 0; i < 2; i++) begin
      weLow[i] = 0; oeLow[i] = 0; selCnt[i] = 0; stabErr[i] = 0; contErr[i] = 0;
      pinErr[i] = 0; hz[i] = 1000; wrPrev[i] = 1'b0; lastD[i] = '0; pendD[i] = '0; pendA[i] = 0;
    end
    pendL = '0;
  end

  always @(negedge clk) begin
    if (rstN) begin
      // word side
      if (!weNW) weLow[0]++;
      if (!oeNW) oeLow[0]++;
      if (!csNW) selCnt[0]++;
      if (byteNW !== 1'b1 || (!weNW && !oeNW)) pinErr[0]++;
      if (!oeNW) hz[0] = 0; else if (hz[0] < 1000) hz[0]++;
      if ((hz[0] <= hzE[0]) && (dqOeW != 16'h0)) contErr[0]++;
      if (!csNW && cs2W && !weNW && (!lbNW || !ubNW)) begin
        if (wrPrev[0] && ((dqOutW & dqOeW) != lastD[0])) stabErr[0]++;
        lastD[0] = dqOutW & dqOeW;
        pendA[0] = int'(mAddrW); pendD[0] = dqOutW; pendL = {!ubNW, !lbNW};
        wrPrev[0] = 1'b1;
      end else begin
        if (wrPrev[0]) begin
          wMem[pendA[0]] = {pendL[1] ? pendD[0][15:8] : peekW(pendA[0])[15:8],
                            pendL[0] ? pendD[0][7:0]  : peekW(pendA[0])[7:0]};
        end
        wrPrev[0] = 1'b0;
      end
      // byte side
      if (!weNB) weLow[1]++;
      if (!oeNB) oeLow[1]++;
      if (!csNB) selCnt[1]++;
      if (byteNB !== 1'b0 || (!csNB && (lbNB || ubNB)) || (!weNB && !oeNB)) pinErr[1]++;
      if (!oeNB) hz[1] = 0; else if (hz[1] < 1000) hz[1]++;
      if ((hz[1] <= hzE[1]) && ((dqOeB & 16'h00FF) != 16'h0)) contErr[1]++;
      if (!csNB && cs2B && !weNB) begin
        if (wrPrev[1] && ((dqOutB & dqOeB) != lastD[1])) stabErr[1]++;
        lastD[1] = dqOutB & dqOeB;
        pendA[1] = int'({mAddrB, dqOutB[15]}); pendD[1] = dqOutB;
        wrPrev[1] = 1'b1;
      end else begin
        if (wrPrev[1]) bMem[pendA[1]] = pendD[1][7:0];
        wrPrev[1] = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one host access; returns read data, busy cycles and monitor deltas
  task automatic access(input int idx, input logic w, input logic [20:0] a, input logic [15:0] d,
                        input logic [1:0] be, output logic [15:0] rd, output int busy,
                        output int dWe, output int dOe, output int dSel);
    int we0, oe0, sel0;
    logic dn, rdy;
    we0 = weLow[idx]; oe0 = oeLow[idx]; sel0 = selCnt[idx];
    @(negedge clk);
    if (idx == 0) begin reqW = 1; wrW = w; hAddrW = a[19:0]; hWdW = d; hBeW = be; end
    else begin reqB = 1; wrB = w; hAddrB = a; hWdB = d[7:0]; hBeB = be; end
    busy = 0; rd = '0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      reqW = 0; reqB = 0;
      dn  = (idx == 0) ? doneW : doneB;
      rdy = (idx == 0) ? readyW : readyB;
      if (dn) begin
        rd = (idx == 0) ? rdW : {8'h00, rdB};
        break;
      end
      if (!rdy) busy++;
    end
    @(negedge clk);
    check("R9 done single cycle", int'((idx == 0) ? doneW : doneB), 0);
    dWe = weLow[idx] - we0; dOe = oeLow[idx] - oe0; dSel = selCnt[idx] - sel0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int busy, dWe, dOe, dSel;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", int'(readyW), 1);
    check("R1 done", int'(doneW), 0);
    check("R1 pins", int'({csNW, cs2W, weNW, oeNW, lbNW, ubNW}), 6'b101111);
    check("R1 bus", int'(dqOeW | dqOeB), 0);
    check("R1 byte pins", int'({csNB, cs2B, weNB, oeNB}), 4'b1011);
    rstN = 1'b1;
    @(negedge clk);

    // word write: R2 R3 R10
    access(0, 1, 21'd5, 16'h1234, 2'b11, rd, busy, dWe, dOe, dSel);
    check("R3 write busy", busy, 1 + wpE[0] + recE[0]);
    check("R2 we pulse", dWe, wpE[0]);
    check("R10 oe in write", dOe, 0);
    check("R2 stored", int'(peekW(5)), 16'h1234);
    // word read: R4 R5 R10
    access(0, 0, 21'd5, 16'h0, 2'b11, rd, busy, dWe, dOe, dSel);
    check("R4 read data", int'(rd), 16'h1234);
    check("R4 oe window", dOe, rdE[0]);
    check("R5 read busy", busy, 1 + rdE[0] + hzE[0]);
    check("R10 we in read", dWe, 0);
    // lanes: R6
    access(0, 1, 21'd5, 16'hABCD, 2'b01, rd, busy, dWe, dOe, dSel);
    check("R6 lower lane only", int'(peekW(5)), 16'h12CD);
    access(0, 1, 21'd5, 16'h56EF, 2'b10, rd, busy, dWe, dOe, dSel);
    check("R6 upper lane only", int'(peekW(5)), 16'h56CD);
    access(0, 0, 21'd5, 16'h0, 2'b01, rd, busy, dWe, dOe, dSel);
    check("R6 masked read", int'(rd), 16'h00CD);
    access(0, 0, 21'd5, 16'h0, 2'b10, rd, busy, dWe, dOe, dSel);
    check("R6 upper read", int'(rd), 16'h5600);
    // write right after read, different address, then read back
    access(0, 1, 21'hFFFFF, 16'h8001, 2'b11, rd, busy, dWe, dOe, dSel);
    access(0, 0, 21'hFFFFF, 16'h0, 2'b11, rd, busy, dWe, dOe, dSel);
    check("R4 top address", int'(rd), 16'h8001);
    // zero enables: R8
    access(0, 1, 21'd5, 16'h0000, 2'b00, rd, busy, dWe, dOe, dSel);
    check("R8 no busy", busy, 0);
    check("R8 no select", dSel, 0);
    check("R8 memory kept", int'(peekW(5)), 16'h56CD);

    // byte instance: R7 R11
    access(1, 1, 21'd6, 16'h0011, 2'b01, rd, busy, dWe, dOe, dSel);
    check("R11 byte write busy", busy, 1 + wpE[1] + recE[1]);
    check("R11 byte we pulse", dWe, wpE[1]);
    access(1, 1, 21'd7, 16'h0022, 2'b11, rd, busy, dWe, dOe, dSel);
    check("R7 even byte", int'(peekB(6)), 8'h11);
    check("R7 odd byte", int'(peekB(7)), 8'h22);
    access(1, 0, 21'd6, 16'h0, 2'b01, rd, busy, dWe, dOe, dSel);
    check("R7 read even", int'(rd), 8'h11);
    check("R5 byte read busy", busy, 1 + rdE[1] + hzE[1]);
    check("R4 byte oe window", dOe, rdE[1]);
    access(1, 0, 21'd7, 16'h0, 2'b10, rd, busy, dWe, dOe, dSel);
    check("R7 read odd", int'(rd), 8'h22);
    access(1, 0, 21'd7, 16'h0, 2'b00, rd, busy, dWe, dOe, dSel);
    check("R8 byte no select", dSel, 0);

    // monitor totals
    check("R2 data stable word", stabErr[0], 0);
    check("R2 data stable byte", stabErr[1], 0);
    check("R5 contention word", contErr[0], 0);
    check("R5 contention byte", contErr[1], 0);
    check("R6 word pins", pinErr[0], 0);
    check("R7 byte pins", pinErr[1], 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule